// File: doc/BRIEF.md
# I2C Forward Address Pass-Through Filter

This block sits on a local I2C bus as a silent observer and decides, once per transaction, whether that transaction should be carried across a control channel to a remote side. After every START or repeated START it collects the 7-bit target address that follows. It then compares that address with three programmable identifiers: the address of the local device, the address of the remote deserializer and the address of one remote slave.

A single mode input chooses the forwarding policy. This input is the most significant bit (bit 7) of an 8-bit control byte held elsewhere. That byte resets to zero, so the restricted policy is in force after reset. In pass-all mode, every address other than the local one is forwarded. In restricted mode, only the two remote identifiers are forwarded. A transaction aimed at the local device is never forwarded and raises a local-hit flag instead.

Both flags are registered and stay unchanged for the rest of the transaction. They drop at STOP, and they drop at a repeated START, which begins a fresh evaluation.

Top module: `i2c_fwd_filter`

## Requirements
- R1: A START is recognised when SDA falls while SCL is high. A STOP is recognised when SDA rises while SCL is high. SDA changes while SCL is low are not bus conditions.
- R2: After a START, the first 7 SCL rising edges shift in the address, MSB first. The decision is made on the 8th rising edge. The value of the 8th bit (R/W) has no effect on the result.
- R3: An address equal to `local_id` sets `local_hit` to 1 and leaves `fwd_en` at 0, in either mode.
- R4: With `pass_all_en` = 1, any address that differs from `local_id` sets `fwd_en` to 1.
- R5: With `pass_all_en` = 0, `fwd_en` becomes 1 only if the address equals `deser_id` or `remote_id`. Any other non-local address leaves both flags at 0.
- R6: Once made, the decision holds until the next STOP or START. Later data bytes, including ones equal to an identifier, do not change it.
- R7: A STOP clears both flags.
- R8: A repeated START clears both flags. The address that follows it is evaluated afresh.
- R9: If a STOP is detected in the same clock cycle that the decision would be registered, the flags end up cleared.
- R10: During and after reset, both flags are 0.
- R11: `fwd_en` and `local_hit` are never 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Raw SCL level observed on the bus |
| sda_in | input | 1 | Raw SDA level observed on the bus |
| pass_all_en | input | 1 | Forwarding policy: 1 selects pass-all, 0 selects the two remote IDs only (bit 7 of the control byte) |
| local_id | input | 7 | Address of the local device |
| deser_id | input | 7 | Address of the remote deserializer |
| remote_id | input | 7 | Address of the remote slave |
| fwd_en | output | 1 | Transaction is being forwarded |
| local_hit | output | 1 | Transaction targets the local device |

## Verification
The decision strobe that follows the 8th SCL rising edge can land in the same clock cycle as a STOP detection. The bench provokes this by raising SCL for the 8th address bit and raising SDA exactly one clock later. Both lines pass through identical synchronizers, so the one-cycle gap is preserved and the two events coincide inside the block. The address used is the remote deserializer ID, which would otherwise be forwarded. The bench then requires both flags to read 0. If the decision were given priority over the clear, `fwd_en` would remain at 1 on an idle bus.

// File: rtl/i2c_fwd_pkg.sv
// Shared types for the I2C forward filter.
// Assumes: one bus-event bundle is produced per clock by the condition detector.
package i2c_fwd_pkg;

    // Bus conditions seen in the current clock cycle
    typedef struct packed {
        logic start;     // START or repeated START
        logic stop;      // STOP
        logic scl_rise;  // SCL rising edge
    } bus_evt_t;

    // Policy encodings of the pass-all mode bit
    localparam logic POLICY_WHITELIST = 1'b0;
    localparam logic POLICY_PASS_ALL  = 1'b1;

endpackage

// File: rtl/i2c_line_sync.sv
// Synchronizes raw SCL and SDA into the clock domain and keeps a one-cycle
// delayed copy of each, so that edges can be found downstream.
// Assumes: STAGES >= 1; the idle bus level is high, so every flop resets to 1.
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_raw,
    input  logic sda_raw,
    output logic scl_now,
    output logic sda_now,
    output logic scl_prev,
    output logic sda_prev
);
    localparam int LINES = 2;

    logic [LINES-1:0] raw_vec;
    logic [LINES-1:0] chain [STAGES];

    assign raw_vec = {scl_raw, sda_raw};

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            // Purpose: one synchronizer rank for both lines
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    chain[g] <= '1;
                end else if (g == 0) begin
                    chain[g] <= raw_vec;
                end else begin
                    chain[g] <= chain[(g == 0) ? 0 : g-1];
                end
            end
        end
    endgenerate

    assign scl_now = chain[STAGES-1][1];
    assign sda_now = chain[STAGES-1][0];

    // Purpose: hold previous synchronized levels for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_prev <= scl_now;
            sda_prev <= sda_now;
        end
    end
endmodule

// File: rtl/i2c_cond_detect.sv
// Turns the current and previous synchronized line levels into START,
// STOP and SCL-rise events.
// Assumes: inputs are already synchronized; output is combinational.
module i2c_cond_detect
    import i2c_fwd_pkg::*;
(
    input  logic     scl_now,
    input  logic     sda_now,
    input  logic     scl_prev,
    input  logic     sda_prev,
    output bus_evt_t evt
);
    logic scl_held_high;

    assign scl_held_high = scl_now & scl_prev;

    // Purpose: classify SDA edges during SCL high and find SCL rising edges
    always_comb begin
        evt.start    = scl_held_high &  sda_prev & ~sda_now;
        evt.stop     = scl_held_high & ~sda_prev &  sda_now;
        evt.scl_rise = scl_now & ~scl_prev;
    end
endmodule

// File: rtl/i2c_addr_capture.sv
// Shifts in the 7-bit address after START, MSB first. On the 8th SCL rise
// (the R/W bit) it pulses addr_done for one cycle, then ignores the bus
// until the next START.
// Assumes: STOP returns the counter to idle.
module i2c_addr_capture
    import i2c_fwd_pkg::*;
#(
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  bus_evt_t          evt,
    input  logic              sda_now,
    output logic [ADDR_W-1:0] addr,
    output logic              addr_done
);
    localparam int BYTE_W = ADDR_W + 1;
    localparam int CNT_W  = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] IDLE_CNT = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(BYTE_W - 1);
    localparam logic [CNT_W-1:0] ADDR_END = CNT_W'(ADDR_W);

    logic [CNT_W-1:0]  bit_cnt;
    logic [ADDR_W-1:0] shreg;

    // Purpose: count address bits and shift them in, restart on START
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt   <= IDLE_CNT;
            shreg     <= '0;
            addr_done <= 1'b0;
        end else begin
            addr_done <= 1'b0;
            if (evt.start) begin
                bit_cnt <= '0;
            end else if (evt.stop) begin
                bit_cnt <= IDLE_CNT;
            end else if (evt.scl_rise && bit_cnt != IDLE_CNT) begin
                bit_cnt <= bit_cnt + 1'b1;
                if (bit_cnt < ADDR_END) begin
                    shreg <= {shreg[ADDR_W-2:0], sda_now};
                end
                if (bit_cnt == LAST_CNT) begin
                    addr_done <= 1'b1;
                end
            end
        end
    end

    assign addr = shreg;

    // R2: the counter never passes the idle value
    a_r2_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= IDLE_CNT);

    // R2: a decision strobe follows an SCL rising edge
    a_r2_done_after_rise: assert property (@(posedge clk) disable iff (!rst_n)
        addr_done |-> $past(evt.scl_rise));

    // R8: START restarts the address count
    a_r8_restart_count: assert property (@(posedge clk) disable iff (!rst_n)
        evt.start |=> (bit_cnt == '0));
endmodule

// File: rtl/i2c_fwd_decide.sv
// Compares the captured address with the three identifiers, applies the
// selected policy and holds the result until STOP or START.
// Assumes: a clear (STOP/START) takes priority over a decision in the same cycle.
module i2c_fwd_decide
    import i2c_fwd_pkg::*;
#(
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  bus_evt_t          evt,
    input  logic [ADDR_W-1:0] addr,
    input  logic              addr_done,
    input  logic              pass_all_en,
    input  logic [ADDR_W-1:0] local_id,
    input  logic [ADDR_W-1:0] deser_id,
    input  logic [ADDR_W-1:0] remote_id,
    output logic              fwd_en,
    output logic              local_hit
);
    logic is_local;
    logic is_listed;
    logic want_fwd;

    // Purpose: address matching and policy selection
    always_comb begin
        is_local  = (addr == local_id);
        is_listed = (addr == deser_id) || (addr == remote_id);
        if (pass_all_en == POLICY_PASS_ALL) begin
            want_fwd = !is_local;
        end else begin
            want_fwd = !is_local && is_listed;
        end
    end

    // Purpose: latch the decision, clear on STOP or START
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fwd_en    <= 1'b0;
            local_hit <= 1'b0;
        end else if (evt.stop || evt.start) begin
            fwd_en    <= 1'b0;
            local_hit <= 1'b0;
        end else if (addr_done) begin
            fwd_en    <= want_fwd;
            local_hit <= is_local;
        end
    end

    // R11: the two flags are exclusive
    a_r11_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(fwd_en && local_hit));

    // R7: STOP clears both flags
    a_r7_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
        evt.stop |=> (!fwd_en && !local_hit));

    // R8: START clears both flags
    a_r8_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        evt.start |=> (!fwd_en && !local_hit));

    // R6: without a strobe or bus condition the flags hold
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!addr_done && !evt.start && !evt.stop) |=> ($stable(fwd_en) && $stable(local_hit)));
endmodule

// File: rtl/i2c_fwd_filter.sv
// Top of the I2C forward address filter: synchronizer, condition detector,
// address capture and policy decision in series.
// Assumes: clk is many times faster than SCL; identifiers are quasi-static.
module i2c_fwd_filter
    import i2c_fwd_pkg::*;
#(
    parameter int ADDR_W      = 7,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    input  logic              pass_all_en,
    input  logic [ADDR_W-1:0] local_id,
    input  logic [ADDR_W-1:0] deser_id,
    input  logic [ADDR_W-1:0] remote_id,
    output logic              fwd_en,
    output logic              local_hit
);
    logic              scl_now, sda_now, scl_prev, sda_prev;
    bus_evt_t          evt;
    logic [ADDR_W-1:0] addr;
    logic              addr_done;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_raw  (scl_in),
        .sda_raw  (sda_in),
        .scl_now  (scl_now),
        .sda_now  (sda_now),
        .scl_prev (scl_prev),
        .sda_prev (sda_prev)
    );

    i2c_cond_detect u_cond (
        .scl_now  (scl_now),
        .sda_now  (sda_now),
        .scl_prev (scl_prev),
        .sda_prev (sda_prev),
        .evt      (evt)
    );

    i2c_addr_capture #(.ADDR_W(ADDR_W)) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt       (evt),
        .sda_now   (sda_now),
        .addr      (addr),
        .addr_done (addr_done)
    );

    i2c_fwd_decide #(.ADDR_W(ADDR_W)) u_dec (
        .clk         (clk),
        .rst_n       (rst_n),
        .evt         (evt),
        .addr        (addr),
        .addr_done   (addr_done),
        .pass_all_en (pass_all_en),
        .local_id    (local_id),
        .deser_id    (deser_id),
        .remote_id   (remote_id),
        .fwd_en      (fwd_en),
        .local_hit   (local_hit)
    );

    // R10: flags are low in the cycle after reset
    a_r10_reset_flags: assert property (@(posedge clk)
        !rst_n |=> (!fwd_en && !local_hit));
endmodule

// File: tb/i2c_fwd_filter_tb_top.sv
module i2c_fwd_filter_tb_top;
    localparam int H = 8;  // clocks per bus phase
    localparam logic [6:0] LOC = 7'h1A;
    localparam logic [6:0] DES = 7'h2C;
    localparam logic [6:0] SLV = 7'h50;
    localparam int NV = 10;
    // {pass_all, addr[6:0], rw, exp_fwd, exp_local}
    localparam logic [10:0] VEC [NV] = '{
        {1'b0, 7'h2C, 1'b0, 1'b1, 1'b0},
        {1'b0, 7'h50, 1'b1, 1'b1, 1'b0},
        {1'b0, 7'h1A, 1'b0, 1'b0, 1'b1},
        {1'b0, 7'h33, 1'b0, 1'b0, 1'b0},
        {1'b1, 7'h33, 1'b1, 1'b1, 1'b0},
        {1'b1, 7'h1A, 1'b1, 1'b0, 1'b1},
        {1'b1, 7'h2C, 1'b0, 1'b1, 1'b0},
        {1'b0, 7'h7F, 1'b1, 1'b0, 1'b0},
        {1'b1, 7'h00, 1'b0, 1'b1, 1'b0},
        {1'b0, 7'h2D, 1'b0, 1'b0, 1'b0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1, sda = 1'b1, pass_all = 1'b0;
    logic fwd_en, local_hit;
    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    i2c_fwd_filter dut_i (
        .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda),
        .pass_all_en(pass_all), .local_id(LOC), .deser_id(DES), .remote_id(SLV),
        .fwd_en(fwd_en), .local_hit(local_hit)
    );

    task automatic wait_ph(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(string req, logic [1:0] act, logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: {fwd,local} actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic bus_start();
        sda = 1'b1; scl = 1'b1; wait_ph(H);
        sda = 1'b0; wait_ph(H);
        scl = 1'b0; wait_ph(H);
    endtask

    task automatic bus_restart();
        sda = 1'b1; wait_ph(H);
        scl = 1'b1; wait_ph(H);
        sda = 1'b0; wait_ph(H);
        scl = 1'b0; wait_ph(H);
    endtask

    task automatic send_bit(logic b);
        sda = b; wait_ph(H);
        scl = 1'b1; wait_ph(H);
        scl = 1'b0; wait_ph(H);
    endtask

    task automatic send_byte(logic [7:0] v);
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        send_bit(1'b1);  // acknowledge slot, released
    endtask

    task automatic bus_stop();
        sda = 1'b0; wait_ph(H);
        scl = 1'b1; wait_ph(H);
        sda = 1'b1; wait_ph(H);
    endtask

    initial begin
        wait_ph(5);
        check("R10 flags during reset", {fwd_en, local_hit}, 2'b00);
        rst_n = 1'b1;
        wait_ph(5);
        check("R10 flags after reset", {fwd_en, local_hit}, 2'b00);

        // Table walk: R2 R3 R4 R5 R6 R7 R11
        for (int v = 0; v < NV; v++) begin
            pass_all = VEC[v][10];
            bus_start();
            send_byte({VEC[v][9:3], VEC[v][2]});
            check($sformatf("R3/R4/R5 vec%0d decision", v), {fwd_en, local_hit}, VEC[v][1:0]);
            send_byte({LOC, 1'b0});
            check($sformatf("R6 vec%0d held over data", v), {fwd_en, local_hit}, VEC[v][1:0]);
            bus_stop();
            check($sformatf("R7 vec%0d cleared at stop", v), {fwd_en, local_hit}, 2'b00);
        end

        // R8: repeated START re-evaluates
        pass_all = 1'b0;
        bus_start();
        send_byte({DES, 1'b0});
        check("R8 before restart", {fwd_en, local_hit}, 2'b10);
        bus_restart();
        check("R8 cleared by restart", {fwd_en, local_hit}, 2'b00);
        send_byte({LOC, 1'b1});
        check("R8 re-evaluated to local", {fwd_en, local_hit}, 2'b01);
        bus_restart();
        send_byte({SLV, 1'b1});
        check("R8 re-evaluated to remote", {fwd_en, local_hit}, 2'b10);
        bus_stop();

        // R1: SDA toggling while SCL low is no condition
        bus_start();
        send_byte({SLV, 1'b0});
        sda = 1'b0; wait_ph(H); sda = 1'b1; wait_ph(H); sda = 1'b0; wait_ph(H);
        check("R1 sda toggles with scl low", {fwd_en, local_hit}, 2'b10);
        bus_stop();
        check("R1 stop recognised", {fwd_en, local_hit}, 2'b00);

        // R2: R/W bit value does not matter (0 vs 1 with pass-all off)
        bus_start();
        send_byte({7'h2C, 1'b1});
        check("R2 rw=1 same decision", {fwd_en, local_hit}, 2'b10);
        bus_stop();

        // R9: STOP lands in the decision cycle
        pass_all = 1'b0;
        bus_start();
        for (int i = 6; i >= 0; i--) send_bit(DES[i]);
        sda = 1'b0; wait_ph(H);
        scl = 1'b1; wait_ph(1);
        sda = 1'b1; wait_ph(4 * H);
        check("R9 stop wins over decision", {fwd_en, local_hit}, 2'b00);
        scl = 1'b1; sda = 1'b1; wait_ph(H);

        // R10: reset mid-transaction clears
        bus_start();
        send_byte({LOC, 1'b0});
        rst_n = 1'b0; wait_ph(3);
        check("R10 reset clears held flag", {fwd_en, local_hit}, 2'b00);
        rst_n = 1'b1; scl = 1'b1; sda = 1'b1; wait_ph(H);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule